// File: doc/BRIEF.md
# Dual-Compare Two-Channel PWM Generator

This block drives two pulse-width-modulated pins from one free-running cycle counter. The period comes from a setting given in hundredths: the effective period in clock cycles is that setting times 100. A single shared period compare marks the start of every period. At that point it raises a one-cycle interrupt pulse and drives both pins to their active level. Each pin also has its own trailing-edge compare that returns the pin to its inactive level. Two compare channels therefore act on every pin, and edges land with single-clock resolution.

Duty settings are percentages from 0 to 100. A duty below one half is folded: the channel runs 100 minus that duty as its on-time with the pin made active-low. A 30 % request thus becomes 70 % active-low, and the pin is still high for 30 % of the period. Period, duty and enable are sampled only at a period boundary, so a period already in progress always completes with the settings it started with. An illegal configuration raises an invalid flag and keeps the generator halted with both pins low.

Top module: `pwm_dual_compare`

## Requirements
- R1: After reset the pins, the interrupt and the invalid flag are all 0.
- R2: While enabled with a valid configuration, each period lasts exactly `period_set` × 100 clock cycles.
- R3: A `period_set` below 2 while `enable` is 1 sets `cfg_invalid` one clock later. No period starts, the pins stay 0 and no interrupt is raised.
- R4: For a duty d ≥ 50, the pin is high from the first cycle of the period for exactly d × `period_set` cycles, then low for the rest of the period.
- R5: For a duty d < 50, the pin is low from the first cycle of the period for (100 − d) × `period_set` cycles, then high for the rest of the period. It is high for d × `period_set` cycles in total.
- R6: A duty of 100 holds the pin high for the whole period and a duty of 0 holds it low. The coinciding period compare wins over the trailing compare, so no trailing edge appears.
- R7: `period_irq` is high for exactly one cycle per period, in the first cycle of the period, and comes only from the period compare.
- R8: A change to a duty or period input during a period has no effect on that period. It takes effect from the next period start.
- R9: Any duty field above 100 (0x64) while `enable` is 1 sets `cfg_invalid` and keeps the generator from starting.
- R10: Clearing `enable` lets the current period finish unchanged. After that no interrupt is raised and both pins are held at 0.
- R11: Channel i takes its duty from bits [7i+6 : 7i] of `duty_pct`, and `pwm_out[i]` is its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request, sampled at period boundaries |
| period_set | input | SET_W (8) | Period in units of 100 cycles; legal values are 2 and above |
| duty_pct | input | CH×7 (14) | Per-channel duty percentage, channel i at bits [7i+6:7i] |
| pwm_out | output | CH (2) | PWM pins |
| period_irq | output | 1 | One-cycle pulse at the start of each period |
| cfg_invalid | output | 1 | Registered flag for an illegal period or duty while enabled |

## Verification
The assertions rely on the period never being shorter than 200 cycles while running, so that two interrupt pulses are never adjacent and each on-time is at least 100 cycles. That keeps the trailing compare from ever underflowing. They also rely on the inputs being sampled only at boundaries. The stimulus changes every input at a falling clock edge, uses only period settings of 2 or more for running cases, and keeps duty fields within their 7-bit range. Illegal settings are applied only to check that the generator refuses to start.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DUTY_W   = 7;
  localparam int PCT_FULL = 100;
  localparam int PCT_HALF = 50;
  localparam int MIN_SET  = 2;

  typedef struct packed {
    logic              act_high;
    logic [DUTY_W-1:0] eff;
  } fold_t;

  // Fold a low duty into its complement with inverted polarity.
  function automatic fold_t fold_duty(input logic [DUTY_W-1:0] d);
    fold_t f;
    if (d >= DUTY_W'(PCT_HALF)) begin
      f.act_high = 1'b1;
      f.eff      = d;
    end else begin
      f.act_high = 1'b0;
      f.eff      = DUTY_W'(PCT_FULL) - d;
    end
    return f;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic [SET_W-1:0] period_set,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_len_o,
  output logic             run_o,
  output logic             boundary_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] HUNDRED = CNT_W'(PCT_FULL);

  logic [CNT_W-1:0] cnt_q, per_len_q;
  logic             run_q, irq_q;
  logic             period_hit;

  // Shared period compare: last cycle of the running period.
  assign period_hit = run_q && (cnt_q == per_len_q - CNT_W'(1));
  assign boundary_o = !run_q || period_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      per_len_q <= '0;
      run_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (boundary_o) begin
        cnt_q <= '0;
        if (start_ok) begin
          run_q     <= 1'b1;
          per_len_q <= CNT_W'(period_set) * HUNDRED;
          irq_q     <= 1'b1;
        end else begin
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign per_len_o = per_len_q;
  assign run_o     = run_q;
  assign irq_o     = irq_q;

  assert_irq_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (run_q && cnt_q == '0));
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_len_q));
  assert_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_len_q >= CNT_W'(MIN_SET * PCT_FULL)));
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
  import pwm_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              start_ok,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  per_len_i,
  input  logic [SET_W-1:0]  period_set,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pin_o
);
  fold_t            fd;
  logic [CNT_W-1:0] on_q;
  logic             pol_q, pin_q, trail_hit;

  assign fd = fold_duty(duty_i);
  // Per-pin trailing compare; the period compare takes priority below.
  assign trail_hit = run_i && (cnt_i == on_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      pol_q <= 1'b1;
      pin_q <= 1'b0;
    end else if (boundary_i) begin
      if (start_ok) begin
        on_q  <= CNT_W'(fd.eff) * CNT_W'(period_set);
        pol_q <= fd.act_high;
        pin_q <= fd.act_high;
      end else begin
        pin_q <= 1'b0;
      end
    end else if (trail_hit) begin
      pin_q <= ~pol_q;
    end
  end

  assign pin_o = pin_q;

  assert_edge_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_q) |-> $past(boundary_i || trail_hit));
  assert_start_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_i == '0) |-> (pin_q == pol_q));
  assert_full_duty_flat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && on_q == per_len_i) |-> (pin_q == pol_q));
endmodule

// File: rtl/pwm_dual_compare.sv
module pwm_dual_compare
  import pwm_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int CH    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [SET_W-1:0]    period_set,
  input  logic [CH*DUTY_W-1:0] duty_pct,
  output logic [CH-1:0]       pwm_out,
  output logic                period_irq,
  output logic                cfg_invalid
);
  localparam int MAX_LEN = ((1 << SET_W) - 1) * PCT_FULL;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt, per_len;
  logic             run, boundary, start_ok, bad_cfg, invalid_q;
  logic [CH-1:0]    duty_bad;

  for (genvar i = 0; i < CH; i++) begin : g_chk
    assign duty_bad[i] = duty_pct[i*DUTY_W +: DUTY_W] > DUTY_W'(PCT_FULL);
  end

  assign bad_cfg  = (period_set < SET_W'(MIN_SET)) || (|duty_bad);
  assign start_ok = enable && !bad_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) invalid_q <= 1'b0;
    else        invalid_q <= enable && bad_cfg;
  end
  assign cfg_invalid = invalid_q;

  pwm_timebase #(.SET_W(SET_W), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .period_set(period_set),
    .cnt_o(cnt), .per_len_o(per_len), .run_o(run), .boundary_o(boundary),
    .irq_o(period_irq)
  );

  for (genvar i = 0; i < CH; i++) begin : g_ch
    pwm_edge_chan #(.SET_W(SET_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .start_ok(start_ok),
      .run_i(run), .cnt_i(cnt), .per_len_i(per_len), .period_set(period_set),
      .duty_i(duty_pct[i*DUTY_W +: DUTY_W]), .pin_o(pwm_out[i])
    );
  end

  assert_halt_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == '0 && !period_irq));
  assert_invalid_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && bad_cfg) |=> !period_irq);
endmodule

// File: tb/test_pwm_dual_compare.sv
module test_pwm_dual_compare;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  period_set = 8'd0;
  logic [13:0] duty_pct = '0;
  logic [1:0]  pwm_out;
  logic        period_irq, cfg_invalid;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_compare i_pwm_dual_compare (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_set(period_set),
    .duty_pct(duty_pct), .pwm_out(pwm_out), .period_irq(period_irq),
    .cfg_invalid(cfg_invalid)
  );

  typedef struct packed {
    int set; int d0; int d1; int hi0; int hi1; bit l0; bit l1;
  } vec_t;

  // set, duty0, duty1, high cycles ch0, ch1, start level ch0, ch1
  localparam vec_t VECS [6] = '{
    '{2, 75, 30, 150,  60, 1'b1, 1'b0},
    '{2, 100, 0, 200,   0, 1'b1, 1'b0},
    '{3, 50, 49, 150, 147, 1'b1, 1'b0},
    '{2, 1,  99,   2, 198, 1'b0, 1'b1},
    '{5, 64, 10, 320,  50, 1'b1, 1'b0},
    '{4, 90,  0, 360,   0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit en, input int s, input int d0, input int d1);
    enable     = en;
    period_set = 8'(s);
    duty_pct   = {7'(d1), 7'(d0)};
  endtask

  task automatic wait_start();
    int n = 0;
    @(negedge clk);
    while (!period_irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(period_irq, "R2 period start seen", int'(period_irq), 1);
  endtask

  // Called at a negedge in the first cycle of a period.
  task automatic measure(input int per, input int mid_at, input int mid_d0,
                         output int hi0, output int hi1, output int irqs,
                         output bit f0, output bit f1, output bit irq_next);
    hi0 = 0; hi1 = 0; irqs = 0;
    f0 = pwm_out[0]; f1 = pwm_out[1];
    for (int i = 0; i < per; i++) begin
      if (pwm_out[0]) hi0++;
      if (pwm_out[1]) hi1++;
      if (period_irq) irqs++;
      if (i == mid_at) duty_pct[6:0] = 7'(mid_d0);
      @(negedge clk);
    end
    irq_next = period_irq;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hi0, hi1, irqs, cnt_hi, cnt_irq;
    bit f0, f1, nx;

    repeat (3) @(negedge clk);
    check(pwm_out == 2'b00, "R1 pins after reset", int'(pwm_out), 0);
    check(!period_irq, "R1 irq after reset", int'(period_irq), 0);
    check(!cfg_invalid, "R1 invalid after reset", int'(cfg_invalid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: period setting 1 is refused
    set_cfg(1, 1, 75, 75);
    repeat (2) @(negedge clk);
    check(cfg_invalid, "R3 invalid for set=1", int'(cfg_invalid), 1);
    cnt_hi = 0; cnt_irq = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwm_out != 2'b00) cnt_hi++;
      if (period_irq) cnt_irq++;
      @(negedge clk);
    end
    check(cnt_hi == 0, "R3 pins held low", cnt_hi, 0);
    check(cnt_irq == 0, "R3 no irq", cnt_irq, 0);

    // R9: duty above 100 is refused (channel 1 field, R11 position)
    set_cfg(1, 2, 60, 101);
    repeat (2) @(negedge clk);
    check(cfg_invalid, "R9 invalid for duty 101", int'(cfg_invalid), 1);
    cnt_irq = 0;
    for (int i = 0; i < 300; i++) begin
      if (period_irq || pwm_out != 2'b00) cnt_irq++;
      @(negedge clk);
    end
    check(cnt_irq == 0, "R9 no activity", cnt_irq, 0);

    // Vector walk: R2 R4 R5 R6 R7 R11
    foreach (VECS[k]) begin
      set_cfg(1, VECS[k].set, VECS[k].d0, VECS[k].d1);
      wait_start();
      measure(VECS[k].set * 100, -1, 0, hi0, hi1, irqs, f0, f1, nx);
      check(hi0 == VECS[k].hi0, "R4/R5/R6 ch0 high cycles", hi0, VECS[k].hi0);
      check(hi1 == VECS[k].hi1, "R11 ch1 high cycles", hi1, VECS[k].hi1);
      check(f0 == VECS[k].l0, "R5 ch0 start level", int'(f0), int'(VECS[k].l0));
      check(f1 == VECS[k].l1, "R6 ch1 start level", int'(f1), int'(VECS[k].l1));
      check(irqs == 1, "R7 one irq per period", irqs, 1);
      check(nx, "R2 next period starts on time", int'(nx), 1);
      check(!cfg_invalid, "R3 valid config not flagged", int'(cfg_invalid), 0);
    end

    // R8: mid-period duty change waits for the boundary
    set_cfg(1, 2, 60, 70);
    wait_start();
    measure(200, 50, 40, hi0, hi1, irqs, f0, f1, nx);
    check(hi0 == 120, "R8 old duty kept in period", hi0, 120);
    check(f0 == 1'b1, "R8 old polarity kept", int'(f0), 1);
    measure(200, -1, 0, hi0, hi1, irqs, f0, f1, nx);
    check(hi0 == 80, "R8 new duty next period", hi0, 80);
    check(f0 == 1'b0, "R8 new polarity next period", int'(f0), 0);

    // R10: disable mid-period, current period completes, then halt
    cnt_hi = 0; cnt_irq = 0;
    for (int i = 0; i < 400; i++) begin
      if (pwm_out[0]) cnt_hi++;
      if (period_irq && i > 0) cnt_irq++;
      if (i == 10) enable = 1'b0;
      @(negedge clk);
    end
    check(cnt_hi == 80, "R10 period finished unchanged", cnt_hi, 80);
    check(cnt_irq == 0, "R10 no irq after disable", cnt_irq, 0);
    check(pwm_out == 2'b00, "R10 pins low when halted", int'(pwm_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule